// File: doc/BRIEF.md
# Last-Level Cache Power-Mode Sequencer

This block owns the power state of a shared last-level cache and its snoop filter. A requester asks for a target state by raising `req_i` with a 4-bit state code. The sequencer checks that the move is legal from where it stands. If the move needs it, it asks an external flush engine to clean and invalidate the RAMs that are about to lose power. It then moves the four power domains one at a time: control logic, snoop filter, lower ways (0–7) and upper ways (8–15). Finally it returns a one-cycle accept. An illegal request gets a one-cycle deny and leaves everything untouched.

There are eleven states. The four run modes are FULL (all ways), HALF (lower ways only), SFO (snoop filter only) and NOC (no cache). Each of FULL, HALF and SFO has a dynamic-retention variant (FULL_DR, HALF_DR, SFO_DR) and a static-retention variant (FULL_SR, HALF_SR, SFO_SR). The last state is OFF.

The legal transitions are:
- Run steps between neighbours FULL↔HALF, HALF↔SFO and SFO↔NOC.
- Retention entry X→X_DR and X→X_SR, for X in FULL, HALF and SFO.
- Retention exit X_DR→X and X_SR→X.
- Shutdown NOC→OFF, and wake-up OFF→NOC.

The sequencer FSM walks IDLE, then FLUSH and FWAIT (only on a flushing step), then STEP (four cycles), then ACK, then HOLD. An illegal request goes IDLE, then DENY, then HOLD. It leaves HOLD once the request is withdrawn.

Top module: `llc_pwr_seq`

## Requirements
- R1: After reset, `cur_state_o` is 15 (OFF), all four domain outputs are 0, and `accept_o`, `deny_o` and `flush_start_o` are low.
- R2: State codes are:
  - Run modes: FULL=0, HALF=1, SFO=2, NOC=3.
  - Dynamic retention: FULL_DR=4, HALF_DR=5, SFO_DR=6.
  - Static retention: FULL_SR=8, HALF_SR=9, SFO_SR=10.
  - OFF=15.
  
  Domain levels are 0 off, 1 retention, 2 on. After an accepted move, the domains hold the target's levels:
  - Run modes: the control logic is on in every run mode. The snoop filter is on in FULL, HALF and SFO. The lower ways are on in FULL and HALF. The upper ways are on in FULL only. Every other domain is off.
  - Retention variants: each domain that is on in the matching run mode is in retention, and the rest are off. The control logic is on in _DR and off in _SR.
  - OFF: every domain is off.
- R3: Between run modes, only a one-step move among FULL, HALF, SFO and NOC, in that order, is accepted. A skip is denied.
- R4: A retention state is entered only from its matching run mode. It is left only back to that run mode, so DR↔SR moves are denied.
- R5: While the control logic is off (any _SR state, or OFF), the only accepted request is a return to the matching run mode (OFF returns to NOC).
- R6: OFF is entered only from NOC.
- R7: A one-cycle `flush_start_o` pulse is issued on these moves, and on no others:
  - FULL→HALF, with scope 0 (upper ways).
  - HALF→SFO, with scope 1 (all ways).
  - SFO→NOC, with scope 2 (snoop filter).
- R8: On a flushing move, no domain output changes, and no accept is given, before `flush_done_i` has been seen.
- R9: At most one domain changes per cycle. On a move that raises any domain, the order is control logic, snoop filter, lower ways, upper ways. Otherwise the order is reversed. A domain is never on while the domain before it in power-up order is not on.
- R10: Accept is a single-cycle pulse after the last domain update. Deny is a single-cycle pulse one cycle after the request is sampled, with state and domains unchanged. Unused codes (7, 11–14) and requests for the current state are denied. Accept and deny are never high together.
- R11: After a response, a request held high raises no further accept, deny or flush. A new request is taken only after `req_i` has been low for a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Power-state request, held until a response |
| req_state_i | input | 4 | Requested state code |
| accept_o | output | 1 | One-cycle accept pulse |
| deny_o | output | 1 | One-cycle deny pulse |
| cur_state_o | output | 4 | Current state code |
| flush_start_o | output | 1 | One-cycle clean-and-invalidate start |
| flush_scope_o | output | 2 | Flush scope: 0 upper ways, 1 all ways, 2 snoop filter |
| flush_done_i | input | 1 | Flush engine completion |
| pwr_ctl_o | output | 2 | Control-logic domain level |
| pwr_sf_o | output | 2 | Snoop-filter domain level |
| pwr_lo_o | output | 2 | Ways 0–7 domain level |
| pwr_hi_o | output | 2 | Ways 8–15 domain level |

## Verification
The main function is exercised by a walk through the state graph that alternates legal and illegal requests. The illegal ones cover:
- Run-mode skips, up and down.
- Retention-to-retention moves.
- Requests made while the control logic is off.
- Unused codes and same-state requests.

Each denied request shows that the legality check depends on the current state and not only on the target.

Upward moves and downward moves separate the two power orderings. Retention entries and exits separate moves that change levels without any flush from the three flushing steps, which must each carry a distinct scope. A long flush-engine delay shows that domain updates wait for completion rather than following a fixed latency. A request held high after its accept shows that the handshake re-arms only once the request is withdrawn.

// File: rtl/llc_pwr_pkg.sv
package llc_pwr_pkg;

    localparam int STATE_W   = 4;
    localparam int NUM_DOM   = 4;
    localparam int DOM_IDX_W = $clog2(NUM_DOM);
    localparam int SCOPE_W   = 2;

    typedef enum logic [1:0] {
        DP_OFF = 2'd0,
        DP_RET = 2'd1,
        DP_ON  = 2'd2
    } dpwr_e;

    // state code = {kind[1:0], mode[1:0]}
    localparam logic [1:0] KIND_RUN  = 2'd0;
    localparam logic [1:0] KIND_DRET = 2'd1;
    localparam logic [1:0] KIND_SRET = 2'd2;
    localparam logic [1:0] KIND_DOWN = 2'd3;
    localparam logic [1:0] MODE_NOC  = 2'd3;

    localparam logic [STATE_W-1:0] CODE_OFF = 4'hF;

    function automatic logic code_valid(input logic [STATE_W-1:0] c);
        return (c[3:2] == KIND_RUN) ||
               (((c[3:2] == KIND_DRET) || (c[3:2] == KIND_SRET)) && (c[1:0] != MODE_NOC)) ||
               (c == CODE_OFF);
    endfunction

    // Level of domain d (0 ctl, 1 sf, 2 lower ways, 3 upper ways) in state c.
    function automatic logic [1:0] dom_level(input logic [STATE_W-1:0] c, input int unsigned d);
        logic live;
        live = (int'(c[1:0]) + int'(d)) <= (NUM_DOM - 1);
        case (c[3:2])
            KIND_RUN:  return live ? DP_ON : DP_OFF;
            KIND_DRET: return (d == 0) ? DP_ON  : (live ? DP_RET : DP_OFF);
            KIND_SRET: return (d == 0) ? DP_OFF : (live ? DP_RET : DP_OFF);
            default:   return DP_OFF;
        endcase
    endfunction

endpackage

// File: rtl/llc_pwr_rules.sv
module llc_pwr_rules
    import llc_pwr_pkg::*;
#(
    parameter int NDOM = NUM_DOM
) (
    input  logic [STATE_W-1:0]      cur_i,
    input  logic [STATE_W-1:0]      tgt_i,
    output logic                    legal_o,
    output logic                    need_flush_o,
    output logic [SCOPE_W-1:0]      scope_o,
    output logic                    up_o,
    output logic [NDOM-1:0][1:0]    tgt_dom_o
);

    logic [1:0] ck, tk;
    logic [2:0] cm, tm;
    logic       step_down, step_up;
    logic [NDOM-1:0] rise;

    assign ck = cur_i[3:2];
    assign tk = tgt_i[3:2];
    assign cm = {1'b0, cur_i[1:0]};
    assign tm = {1'b0, tgt_i[1:0]};
    assign step_down = (tm == cm + 3'd1);
    assign step_up   = (cm == tm + 3'd1);

    always_comb begin
        legal_o = 1'b0;
        if (code_valid(tgt_i) && (tgt_i != cur_i)) begin
            unique case (ck)
                KIND_RUN: begin
                    unique case (tk)
                        KIND_RUN:            legal_o = step_down || step_up;
                        KIND_DRET, KIND_SRET: legal_o = (tm == cm);
                        default:             legal_o = (cm == 3'd3);
                    endcase
                end
                KIND_DRET, KIND_SRET: legal_o = (tk == KIND_RUN) && (tm == cm);
                default:              legal_o = (tk == KIND_RUN) && (tm == 3'd3);
            endcase
        end
    end

    assign need_flush_o = (ck == KIND_RUN) && (tk == KIND_RUN) && step_down;
    assign scope_o      = tgt_i[1:0] - 2'd1;

    for (genvar d = 0; d < NDOM; d++) begin : g_lvl
        logic [1:0] cur_lvl;
        assign cur_lvl      = dom_level(cur_i, d);
        assign tgt_dom_o[d] = dom_level(tgt_i, d);
        assign rise[d]      = tgt_dom_o[d] > cur_lvl;
    end

    assign up_o = |rise;

endmodule

// File: rtl/llc_pwr_domains.sv
module llc_pwr_domains
    import llc_pwr_pkg::*;
#(
    parameter  int NDOM = NUM_DOM,
    localparam int IW   = $clog2(NDOM)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_en_i,
    input  logic [IW-1:0]         step_idx_i,
    input  logic [NDOM-1:0][1:0]  tgt_dom_i,
    output logic [NDOM-1:0][1:0]  dom_o
);

    logic [1:0] lvl_q [NDOM];

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[d] <= DP_OFF;
            end else if (step_en_i && (step_idx_i == IW'(d))) begin
                lvl_q[d] <= tgt_dom_i[d];
            end
        end
        assign dom_o[d] = lvl_q[d];
    end

    // R9: a domain is on only while its predecessor in power-up order is on
    for (genvar d = 1; d < NDOM; d++) begin : g_ord
        assert_up_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_q[d] == DP_ON) |-> (lvl_q[d-1] == DP_ON))
            else $error("domain %0d on while predecessor is not on", d);
    end

endmodule

// File: rtl/llc_pwr_seq.sv
module llc_pwr_seq
    import llc_pwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [3:0]         req_state_i,
    output logic               accept_o,
    output logic               deny_o,
    output logic [3:0]         cur_state_o,
    output logic               flush_start_o,
    output logic [1:0]         flush_scope_o,
    input  logic               flush_done_i,
    output logic [1:0]         pwr_ctl_o,
    output logic [1:0]         pwr_sf_o,
    output logic [1:0]         pwr_lo_o,
    output logic [1:0]         pwr_hi_o
);

    localparam int IW = DOM_IDX_W;

    typedef enum logic [2:0] {
        S_IDLE, S_DENY, S_FLUSH, S_FWAIT, S_STEP, S_ACK, S_HOLD
    } seq_e;

    seq_e                   seq_q, seq_d;
    logic [STATE_W-1:0]     cur_q, tgt_q, rule_tgt;
    logic [SCOPE_W-1:0]     scope_q, r_scope;
    logic                   up_q, r_up, r_legal, r_flush;
    logic [IW-1:0]          step_q, step_idx;
    logic                   flushed_q, last_step, step_en;
    logic [NUM_DOM-1:0][1:0] tgt_dom, dom_w;

    assign rule_tgt  = (seq_q == S_IDLE) ? req_state_i : tgt_q;
    assign last_step = (step_q == IW'(NUM_DOM - 1));

    llc_pwr_rules #(.NDOM(NUM_DOM)) rules_i (
        .cur_i        (cur_q),
        .tgt_i        (rule_tgt),
        .legal_o      (r_legal),
        .need_flush_o (r_flush),
        .scope_o      (r_scope),
        .up_o         (r_up),
        .tgt_dom_o    (tgt_dom)
    );

    assign step_en  = (seq_q == S_STEP);
    assign step_idx = up_q ? step_q : (IW'(NUM_DOM - 1) - step_q);

    llc_pwr_domains #(.NDOM(NUM_DOM)) doms_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en_i  (step_en),
        .step_idx_i (step_idx),
        .tgt_dom_i  (tgt_dom),
        .dom_o      (dom_w)
    );

    // next-state logic
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            S_IDLE: begin
                if (req_i) begin
                    if (!r_legal)     seq_d = S_DENY;
                    else if (r_flush) seq_d = S_FLUSH;
                    else              seq_d = S_STEP;
                end
            end
            S_FLUSH: seq_d = S_FWAIT;
            S_FWAIT: if (flush_done_i) seq_d = S_STEP;
            S_STEP:  if (last_step) seq_d = S_ACK;
            S_ACK:   seq_d = S_HOLD;
            S_DENY:  seq_d = S_HOLD;
            S_HOLD:  if (!req_i) seq_d = S_IDLE;
            default: seq_d = S_IDLE;
        endcase
    end

    // state and context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= S_IDLE;
            cur_q     <= CODE_OFF;
            tgt_q     <= CODE_OFF;
            scope_q   <= '0;
            up_q      <= 1'b0;
            step_q    <= '0;
            flushed_q <= 1'b0;
        end else begin
            seq_q <= seq_d;
            if ((seq_q == S_IDLE) && req_i) begin
                tgt_q     <= req_state_i;
                scope_q   <= r_scope;
                up_q      <= r_up;
                step_q    <= '0;
                flushed_q <= 1'b0;
            end
            if ((seq_q == S_FWAIT) && flush_done_i) begin
                flushed_q <= 1'b1;
            end
            if (seq_q == S_STEP) begin
                step_q <= step_q + 1'b1;
                if (last_step) cur_q <= tgt_q;
            end
        end
    end

    // outputs
    always_comb begin
        accept_o      = (seq_q == S_ACK);
        deny_o        = (seq_q == S_DENY);
        flush_start_o = (seq_q == S_FLUSH);
        flush_scope_o = scope_q;
        cur_state_o   = cur_q;
        pwr_ctl_o     = dom_w[0];
        pwr_sf_o      = dom_w[1];
        pwr_lo_o      = dom_w[2];
        pwr_hi_o      = dom_w[3];
    end

    assert_resp_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && deny_o))
        else $error("accept and deny together");

    assert_deny_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> ((cur_state_o == $past(cur_state_o)) && (dom_w == $past(dom_w))))
        else $error("deny changed state");

    assert_accept_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o)
        else $error("accept longer than one cycle");

    assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_start_o |=> !flush_start_o)
        else $error("flush start longer than one cycle");

    // R8: a RAM domain drops from on to off only after flush completion
    for (genvar d = 1; d < NUM_DOM; d++) begin : g_fchk
        assert_flush_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((dom_w[d] == DP_OFF) && ($past(dom_w[d]) == DP_ON)) |-> flushed_q)
            else $error("domain %0d powered off without flush", d);
    end

endmodule

// File: tb/llc_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module llc_pwr_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [3:0] req_state_i = 4'h0;
    logic       flush_done_i = 1'b0;
    logic       accept_o, deny_o, flush_start_o;
    logic [3:0] cur_state_o;
    logic [1:0] flush_scope_o, pwr_ctl_o, pwr_sf_o, pwr_lo_o, pwr_hi_o;

    always #2 clk = ~clk;

    llc_pwr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_state_i(req_state_i),
        .accept_o(accept_o), .deny_o(deny_o), .cur_state_o(cur_state_o),
        .flush_start_o(flush_start_o), .flush_scope_o(flush_scope_o),
        .flush_done_i(flush_done_i), .pwr_ctl_o(pwr_ctl_o), .pwr_sf_o(pwr_sf_o),
        .pwr_lo_o(pwr_lo_o), .pwr_hi_o(pwr_hi_o)
    );

    wire [7:0] dom_vec = {pwr_hi_o, pwr_lo_o, pwr_sf_o, pwr_ctl_o};

    int n_chk = 0;
    int n_bad = 0;
    int resp_cyc;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected {hi, lo, sf, ctl}; 2 on, 1 retention, 0 off (R2)
    function automatic logic [7:0] exp_dom(input logic [3:0] c);
        case (c)
            4'd0:    return {2'd2, 2'd2, 2'd2, 2'd2};
            4'd1:    return {2'd0, 2'd2, 2'd2, 2'd2};
            4'd2:    return {2'd0, 2'd0, 2'd2, 2'd2};
            4'd3:    return {2'd0, 2'd0, 2'd0, 2'd2};
            4'd4:    return {2'd1, 2'd1, 2'd1, 2'd2};
            4'd5:    return {2'd0, 2'd1, 2'd1, 2'd2};
            4'd6:    return {2'd0, 2'd0, 2'd1, 2'd2};
            4'd8:    return {2'd1, 2'd1, 2'd1, 2'd0};
            4'd9:    return {2'd0, 2'd1, 2'd1, 2'd0};
            4'd10:   return {2'd0, 2'd0, 2'd1, 2'd0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tname(input logic [3:0] n);
        case (n)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic run_req(input logic [3:0] tgt, input bit exp_acc, input bit exp_fl,
                           input logic [1:0] exp_sc, input string tag, input int fl_delay);
        logic [7:0] start_dom, exp_d, prev;
        logic [3:0] start_st;
        logic [1:0] sc;
        bit up, got_acc, got_den, fl_seen, done_given, bad_early, bad_multi, bad_order;
        int fl_cnt, last_idx, nchg, idx;
        start_dom = dom_vec;
        start_st  = cur_state_o;
        exp_d     = exp_dom(tgt);
        up = 0;
        for (int d = 0; d < 4; d++) if (exp_d[2*d +: 2] > start_dom[2*d +: 2]) up = 1;
        last_idx = up ? -1 : 4;
        got_acc = 0; got_den = 0; fl_seen = 0; done_given = 0;
        bad_early = 0; bad_multi = 0; bad_order = 0;
        sc = 2'd3; fl_cnt = -1; idx = 0;
        prev = start_dom;
        resp_cyc = 0;
        req_state_i = tgt;
        req_i = 1'b1;
        for (int cyc = 1; cyc <= 400; cyc++) begin
            @(negedge clk);
            if (flush_done_i) begin
                flush_done_i = 1'b0;
                done_given = 1;
            end
            if (flush_start_o) begin
                fl_seen = 1;
                sc = flush_scope_o;
                fl_cnt = fl_delay;
            end else if (fl_cnt > 0) begin
                fl_cnt--;
            end
            if (fl_cnt == 0) begin
                flush_done_i = 1'b1;
                fl_cnt = -1;
            end
            if (dom_vec != prev) begin
                nchg = 0;
                for (int d = 0; d < 4; d++) begin
                    if (dom_vec[2*d +: 2] != prev[2*d +: 2]) begin
                        nchg++;
                        idx = d;
                    end
                end
                if (nchg > 1) bad_multi = 1;
                if (exp_fl && !done_given) bad_early = 1;
                if (up ? (idx <= last_idx) : (idx >= last_idx)) bad_order = 1;
                last_idx = idx;
                prev = dom_vec;
            end
            if (accept_o || deny_o) begin
                got_acc = accept_o;
                got_den = deny_o;
                resp_cyc = cyc;
                break;
            end
        end
        req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (exp_acc) begin
            chk(got_acc && !got_den, {tag, " legal request accepted"}, int'(got_acc), 1);
            chk(cur_state_o == tgt, "R2 state code after accept", int'(cur_state_o), int'(tgt));
            chk(dom_vec == exp_d, "R2 domain levels after accept", int'(dom_vec), int'(exp_d));
            chk(fl_seen == exp_fl, "R7 flush issued only when needed", int'(fl_seen), int'(exp_fl));
            if (exp_fl) chk(sc == exp_sc, "R7 flush scope", int'(sc), int'(exp_sc));
            chk(!bad_early, "R8 domains held until flush done", int'(bad_early), 0);
            chk(!bad_multi && !bad_order, "R9 one domain per cycle in order",
                int'({bad_multi, bad_order}), 0);
        end else begin
            chk(got_den && !got_acc, {tag, " illegal request denied"}, int'(got_den), 1);
            chk(resp_cyc == 1, "R10 deny one cycle after request", resp_cyc, 1);
            chk((cur_state_o == start_st) && (dom_vec == start_dom), "R10 deny keeps state",
                int'({cur_state_o, dom_vec}), int'({start_st, start_dom}));
            chk(!fl_seen, "R10 no flush on deny", int'(fl_seen), 0);
        end
    endtask

    // {req tag, target, accept expected, flush expected, scope}
    localparam int NV = 30;
    localparam logic [11:0] VECS [NV] = '{
        {4'd5,  4'd0,  1'b0, 1'b0, 2'd0},   // OFF -> FULL denied (R5)
        {4'd5,  4'd3,  1'b1, 1'b0, 2'd0},   // OFF -> NOC
        {4'd3,  4'd1,  1'b0, 1'b0, 2'd0},   // NOC -> HALF skip (R3)
        {4'd3,  4'd2,  1'b1, 1'b0, 2'd0},
        {4'd3,  4'd1,  1'b1, 1'b0, 2'd0},
        {4'd3,  4'd0,  1'b1, 1'b0, 2'd0},
        {4'd3,  4'd2,  1'b0, 1'b0, 2'd0},   // FULL -> SFO skip
        {4'd4,  4'd4,  1'b1, 1'b0, 2'd0},   // FULL -> FULL_DR
        {4'd4,  4'd8,  1'b0, 1'b0, 2'd0},   // DR -> SR denied
        {4'd4,  4'd0,  1'b1, 1'b0, 2'd0},
        {4'd4,  4'd8,  1'b1, 1'b0, 2'd0},   // FULL -> FULL_SR
        {4'd5,  4'd3,  1'b0, 1'b0, 2'd0},   // FULL_SR -> NOC denied
        {4'd5,  4'd0,  1'b1, 1'b0, 2'd0},
        {4'd7,  4'd1,  1'b1, 1'b1, 2'd0},   // FULL -> HALF, upper flush
        {4'd4,  4'd5,  1'b1, 1'b0, 2'd0},
        {4'd4,  4'd1,  1'b1, 1'b0, 2'd0},
        {4'd4,  4'd9,  1'b1, 1'b0, 2'd0},
        {4'd5,  4'd1,  1'b1, 1'b0, 2'd0},
        {4'd7,  4'd2,  1'b1, 1'b1, 2'd1},   // HALF -> SFO, all-ways flush
        {4'd4,  4'd10, 1'b1, 1'b0, 2'd0},
        {4'd6,  4'd15, 1'b0, 1'b0, 2'd0},   // SFO_SR -> OFF denied
        {4'd5,  4'd2,  1'b1, 1'b0, 2'd0},
        {4'd4,  4'd6,  1'b1, 1'b0, 2'd0},
        {4'd4,  4'd2,  1'b1, 1'b0, 2'd0},
        {4'd7,  4'd3,  1'b1, 1'b1, 2'd2},   // SFO -> NOC, snoop filter flush
        {4'd10, 4'd7,  1'b0, 1'b0, 2'd0},   // unused code
        {4'd10, 4'd3,  1'b0, 1'b0, 2'd0},   // same state
        {4'd4,  4'd4,  1'b0, 1'b0, 2'd0},   // NOC -> FULL_DR denied
        {4'd6,  4'd15, 1'b1, 1'b0, 2'd0},   // NOC -> OFF
        {4'd5,  4'd9,  1'b0, 1'b0, 2'd0}    // OFF -> HALF_SR denied
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cur_state_o == 4'd15, "R1 reset state code", int'(cur_state_o), 15);
        chk(dom_vec == 8'h00, "R1 reset domains off", int'(dom_vec), 0);
        chk(!accept_o && !deny_o && !flush_start_o, "R1 reset handshake idle",
            int'({accept_o, deny_o, flush_start_o}), 0);

        for (int i = 0; i < NV; i++) begin
            run_req(VECS[i][7:4], VECS[i][3], VECS[i][2], VECS[i][1:0],
                    tname(VECS[i][11:8]), 3);
        end

        // R8: slow flush engine, accept must wait
        run_req(4'd3, 1'b1, 1'b0, 2'd0, "R5", 3);
        run_req(4'd2, 1'b1, 1'b0, 2'd0, "R3", 3);
        run_req(4'd1, 1'b1, 1'b0, 2'd0, "R3", 3);
        run_req(4'd0, 1'b1, 1'b0, 2'd0, "R3", 3);
        run_req(4'd1, 1'b1, 1'b1, 2'd0, "R8", 30);
        chk(resp_cyc >= 30, "R8 accept waits for flush done", resp_cyc, 30);

        // R11: request held high after accept
        req_state_i = 4'd5;
        req_i = 1'b1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (accept_o) break;
        end
        chk(cur_state_o == 4'd5, "R11 held request accepted once", int'(cur_state_o), 5);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!accept_o && !deny_o && !flush_start_o, "R11 quiet while request held",
                int'({accept_o, deny_o, flush_start_o}), 0);
        end
        req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        run_req(4'd1, 1'b1, 1'b0, 2'd0, "R11", 3);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cur_state_o == 4'd15, "R1 state after mid-run reset", int'(cur_state_o), 15);
        chk(dom_vec == 8'h00, "R1 domains after mid-run reset", int'(dom_vec), 0);

        summary();
        $finish;
    end

endmodule